// File: doc/BRIEF.md
# Systolic Block-Match SAD Search Array

This block runs an exhaustive block-matching search for one 16x16 macroblock of the current frame. It tries every candidate displacement in a window of -8 to +7 pixels on both axes. A chain of sixteen processing elements works on the problem. Each element owns one horizontal displacement. All elements take the same vertical displacement during one pass of 64 steps. A pass runs the sixteen sub-blocks of the macroblock through every element, one 4-pixel row per step, so each element finishes a 4x4 sum of absolute differences every four cycles. Sixteen passes cover all 256 candidates.

Current-frame rows enter at the head of the chain. A row moves one element further along the chain on every cycle, together with a control token that carries its row, sub-block and pass index. Each element therefore runs one cycle behind its left neighbour, and after a fill of sixteen cycles every element is busy on every cycle. An outside memory supplies the reference pixels on one lane per element. For each candidate the block emits a group of sixteen 4x4 SADs, tagged with the signed motion vector. When the last candidate is out it emits a done pulse. A later stage can combine the sixteen SADs into larger partitions.

Top module: `sad_search_array`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `grp_valid_o`, `done_o`, `grp_sad_o` and `grp_mv_o` are all zero.
- R2: A `start_i` sampled high while the array is idle begins a search. A `start_i` sampled high while a search is running has no effect: the number of groups, their timing and the done pulse stay the same.
- R3: Each group entry is the sum over a 4x4 sub-block of |cur - ref|. Entry b sits at `grp_sad_o[b*12 +: 12]`, where b = by*4 + bx numbers the sub-blocks in raster order (bx is the column, by the row, each 0..3).
- R4: Take S as the clock edge that samples the accepted start. Step s (0..1023) has row r = s%4, sub-block b = (s/4)%16 and pass p = s/64. `cur_row_i` is sampled for step s at edge S+1+s, and byte j holds cur(y=by*4+r, x=bx*4+j). Reference lane k is sampled for step s at edge S+1+s+k, and byte j of the lane holds the window pixel at row by*4+r+p and column bx*4+j+k. The window is 31x31 with its origin at displacement (-8,-8). Lane k sits at bits `[k*32 +: 32]` of `ref_rows_i`.
- R5: The group for pass p and element k is valid for exactly one cycle, the cycle after edge S+64p+64+k.
- R6: `grp_mv_o[4:0]` carries dx = k-8 and `grp_mv_o[9:5]` carries dy = p-8, each as 5-bit two's complement.
- R7: A search gives exactly 256 groups, ordered by pass first and then by element. Within a pass the 16 groups come on 16 consecutive cycles.
- R8: `done_o` is high for exactly one cycle: the cycle after the last group, which follows edge S+1040.
- R9: With a full-contrast block (cur = 255, ref = 0) every entry equals 4080. No entry wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a search when the array is idle |
| cur_row_i | input | 32 | Four current-frame pixels for the step at the head of the chain |
| ref_rows_i | input | 512 | Sixteen reference lanes of four pixels, one lane per element |
| grp_valid_o | output | 1 | A group of sixteen SADs is present |
| grp_sad_o | output | 192 | Sixteen 12-bit 4x4 SADs, in raster order by sub-block |
| grp_mv_o | output | 10 | {dy, dx} motion vector of the group |
| done_o | output | 1 | One-cycle pulse after the final group |

## Verification
The bench models the full search independently and compares every group against a scoreboard queue, including the cycle in which the group arrives. Getting the stagger wrong by one cycle on the token chain or the reference lanes pairs a row with the wrong reference data, and every SAD and arrival time then mismatches. Sub-block order errors in the shift register show up as entries swapped inside a group, and a wrong sign in the vector encoding corrupts `grp_mv_o`. The full-contrast pattern catches an accumulator that is too narrow, because the entries wrap below 4080. A start pulse in the middle of a run catches a sequencer that restarts, because the result is extra or missing groups and a late done pulse.

// File: rtl/sad_pkg.sv
package sad_pkg;

    localparam int PIX_W  = 8;    // bits per pixel
    localparam int SUB    = 4;    // sub-block edge in pixels
    localparam int MB     = 16;   // macroblock edge in pixels
    localparam int SPAN   = 16;   // displacements per axis, also the element count

    localparam int SUB_PER_ROW   = MB / SUB;
    localparam int NSUB          = SUB_PER_ROW * SUB_PER_ROW;
    localparam int STEPS_PER_POS = NSUB * SUB;
    localparam int TOTAL_STEPS   = STEPS_PER_POS * SPAN;
    localparam int ROW_IDX_W     = $clog2(SUB);
    localparam int SUB_IDX_W     = $clog2(NSUB);
    localparam int PASS_W        = $clog2(SPAN);
    localparam int STEP_W        = $clog2(TOTAL_STEPS);
    localparam int SAD_W         = $clog2(SUB * SUB * ((1 << PIX_W) - 1) + 1);
    localparam int MV_W          = $clog2(SPAN) + 1;
    localparam int ROW_BITS      = SUB * PIX_W;
    localparam int GRP_BITS      = NSUB * SAD_W;

    typedef logic [PIX_W-1:0]          pix_t;
    typedef logic [SUB-1:0][PIX_W-1:0] row_t;
    typedef logic [SAD_W-1:0]          sad_t;
    typedef logic [GRP_BITS-1:0]       grp_t;

    typedef struct packed {
        logic                 valid;
        logic [PASS_W-1:0]    pass;
        logic [SUB_IDX_W-1:0] sub;
        logic [ROW_IDX_W-1:0] row;
        row_t                 cur;
    } tok_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FEED,
        SQ_DRAIN
    } seq_state_e;

    function automatic pix_t absdiff(pix_t a, pix_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic logic [MV_W-1:0] offset_of(int idx);
        logic [MV_W-1:0] r;
        r = MV_W'(idx - SPAN / 2);
        return r;
    endfunction

endpackage

// File: rtl/sad_seq.sv
module sad_seq
    import sad_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  row_t  cur_row_i,
    input  logic  last_i,
    output tok_t  tok_o
);

    seq_state_e        state;
    logic [STEP_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_i) begin
                        state <= SQ_FEED;
                        cnt   <= '0;
                    end
                end
                SQ_FEED: begin
                    if (cnt == STEP_W'(TOTAL_STEPS - 1)) begin
                        state <= SQ_DRAIN;
                    end
                    cnt <= cnt + 1'b1;
                end
                SQ_DRAIN: begin
                    if (last_i) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        tok_o.valid = (state == SQ_FEED);
        tok_o.row   = cnt[ROW_IDX_W-1:0];
        tok_o.sub   = cnt[ROW_IDX_W +: SUB_IDX_W];
        tok_o.pass  = cnt[ROW_IDX_W + SUB_IDX_W +: PASS_W];
        tok_o.cur   = cur_row_i;
    end

    // R2: a running search only ends through the final result
    a_r2_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_IDLE && !last_i) |=> (state != SQ_IDLE));

    // R4: one step per cycle while feeding
    a_r4_step_advance: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_FEED && cnt != STEP_W'(TOTAL_STEPS - 1))
            |=> (state == SQ_FEED && cnt == STEP_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/sad_pe.sv
module sad_pe
    import sad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tok_t              tok_i,
    input  row_t              ref_i,
    output logic              fin_o,
    output grp_t              grp_o,
    output logic [PASS_W-1:0] pass_o
);

    sad_t acc;
    sad_t acc_base;
    sad_t row_sum;
    sad_t sum;
    sad_t sh [NSUB-1];

    always_comb begin
        row_sum = '0;
        for (int j = 0; j < SUB; j++) begin
            row_sum = row_sum + SAD_W'(absdiff(tok_i.cur[j], ref_i[j]));
        end
        acc_base = (tok_i.row == '0) ? '0 : acc;
        sum      = acc_base + row_sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            for (int i = 0; i < NSUB - 1; i++) sh[i] <= '0;
        end else if (tok_i.valid) begin
            acc <= sum;
            if (tok_i.row == ROW_IDX_W'(SUB - 1)) begin
                for (int i = 0; i < NSUB - 2; i++) sh[i] <= sh[i+1];
                sh[NSUB-2] <= sum;
            end
        end
    end

    always_comb begin
        fin_o  = tok_i.valid && (tok_i.row == ROW_IDX_W'(SUB - 1))
                 && (tok_i.sub == SUB_IDX_W'(NSUB - 1));
        pass_o = tok_i.pass;
        for (int i = 0; i < NSUB - 1; i++) grp_o[i*SAD_W +: SAD_W] = sh[i];
        grp_o[(NSUB-1)*SAD_W +: SAD_W] = sum;
    end

    // R4: rows within a sub-block arrive on consecutive cycles
    a_r4_rows_contiguous: assert property (@(posedge clk) disable iff (rst)
        (tok_i.valid && tok_i.row != '0) |-> $past(tok_i.valid));

    // R9: accumulation never wraps
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
        tok_i.valid |-> (sum >= acc_base));

endmodule

// File: rtl/sad_search_array.sv
module sad_search_array
    import sad_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic [ROW_BITS-1:0]        cur_row_i,
    input  logic [SPAN*ROW_BITS-1:0]   ref_rows_i,
    output logic                       grp_valid_o,
    output logic [GRP_BITS-1:0]        grp_sad_o,
    output logic [2*MV_W-1:0]          grp_mv_o,
    output logic                       done_o
);

    tok_t              tok     [SPAN];
    logic [SPAN-1:0]   fin;
    grp_t              pe_grp  [SPAN];
    logic [PASS_W-1:0] pe_pass [SPAN];
    logic              last;
    logic              last_q;

    sad_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cur_row_i (row_t'(cur_row_i)),
        .last_i    (last),
        .tok_o     (tok[0])
    );

    for (genvar k = 1; k < SPAN; k++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) tok[k] <= '0;
            else     tok[k] <= tok[k-1];
        end
    end

    for (genvar k = 0; k < SPAN; k++) begin : g_pe
        sad_pe i_pe (
            .clk    (clk),
            .rst    (rst),
            .tok_i  (tok[k]),
            .ref_i  (row_t'(ref_rows_i[k*ROW_BITS +: ROW_BITS])),
            .fin_o  (fin[k]),
            .grp_o  (pe_grp[k]),
            .pass_o (pe_pass[k])
        );
    end

    grp_t            pick_grp;
    logic [MV_W-1:0] pick_dx;
    logic [MV_W-1:0] pick_dy;

    always_comb begin
        pick_grp = '0;
        pick_dx  = '0;
        pick_dy  = '0;
        for (int k = 0; k < SPAN; k++) begin
            if (fin[k]) begin
                pick_grp = pe_grp[k];
                pick_dx  = offset_of(k);
                pick_dy  = offset_of(int'(pe_pass[k]));
            end
        end
        last = fin[SPAN-1] && (pe_pass[SPAN-1] == PASS_W'(SPAN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_valid_o <= 1'b0;
            grp_sad_o   <= '0;
            grp_mv_o    <= '0;
            last_q      <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            grp_valid_o <= |fin;
            if (|fin) begin
                grp_sad_o <= pick_grp;
                grp_mv_o  <= {pick_dy, pick_dx};
            end
            last_q <= last;
            done_o <= last_q;
        end
    end

    // R7: the stagger lets at most one element finish per cycle
    a_r7_one_finisher: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fin));

    // R6: back-to-back groups step dx by one under the same dy
    a_r6_dx_step: assert property (@(posedge clk) disable iff (rst)
        (grp_valid_o && $past(grp_valid_o))
            |-> (grp_mv_o[MV_W-1:0] == MV_W'($past(grp_mv_o[MV_W-1:0]) + 1'b1)
                 && grp_mv_o[2*MV_W-1:MV_W] == $past(grp_mv_o[2*MV_W-1:MV_W])));

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: done follows directly after the final group
    a_r8_done_after_group: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(grp_valid_o) && !grp_valid_o));

endmodule

// File: tb/test_sad_search_array.sv
module test_sad_search_array;
    import sad_pkg::*;

    localparam int WIN = MB + SPAN - 1;

    logic                     clk = 1'b0;
    logic                     rst;
    logic                     start_i;
    logic [ROW_BITS-1:0]      cur_row_i;
    logic [SPAN*ROW_BITS-1:0] ref_rows_i;
    logic                     grp_valid_o;
    logic [GRP_BITS-1:0]      grp_sad_o;
    logic [2*MV_W-1:0]        grp_mv_o;
    logic                     done_o;

    always #5 clk = ~clk;

    sad_search_array i_sad_search_array (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .cur_row_i   (cur_row_i),
        .ref_rows_i  (ref_rows_i),
        .grp_valid_o (grp_valid_o),
        .grp_sad_o   (grp_sad_o),
        .grp_mv_o    (grp_mv_o),
        .done_o      (done_o)
    );

    typedef struct {
        int                  at;
        logic [GRP_BITS-1:0] sads;
        logic [2*MV_W-1:0]   mv;
    } exp_t;

    exp_t q[$];
    int   curf [MB][MB];
    int   reff [WIN][WIN];
    int   total = 0;
    int   bad   = 0;
    bit   full_contrast;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_sad(int p, int k, int b);
        int s = 0;
        int by = b / SUB_PER_ROW;
        int bx = b % SUB_PER_ROW;
        for (int r = 0; r < SUB; r++)
            for (int j = 0; j < SUB; j++) begin
                int d = curf[by*SUB+r][bx*SUB+j] - reff[by*SUB+r+p][bx*SUB+j+k];
                s += (d < 0) ? -d : d;
            end
        return s;
    endfunction

    // driver side of the scoreboard: expected groups in production order
    task automatic push_expected();
        for (int p = 0; p < SPAN; p++)
            for (int k = 0; k < SPAN; k++) begin
                exp_t e;
                e.at = STEPS_PER_POS * p + STEPS_PER_POS + k;
                for (int b = 0; b < NSUB; b++)
                    e.sads[b*SAD_W +: SAD_W] = SAD_W'(exp_sad(p, k, b));
                e.mv = {MV_W'(p - SPAN/2), MV_W'(k - SPAN/2)};
                q.push_back(e);
            end
    endtask

    // monitor side: pop and compare whenever a group shows up
    task automatic monitor(int n);
        if (grp_valid_o) begin
            if (q.size() == 0) begin
                check(0, "R7", "unexpected extra group at edge", n, -1);
            end else begin
                exp_t e = q.pop_front();
                check(e.at == n, "R5", "group edge", n, e.at);
                for (int b = 0; b < NSUB; b++)
                    check(grp_sad_o[b*SAD_W +: SAD_W] == e.sads[b*SAD_W +: SAD_W],
                          full_contrast ? "R9" : "R3 R4", $sformatf("sad entry %0d", b),
                          grp_sad_o[b*SAD_W +: SAD_W], e.sads[b*SAD_W +: SAD_W]);
                check(grp_mv_o == e.mv, "R6", "mv", grp_mv_o, e.mv);
            end
        end
    endtask

    function automatic logic [ROW_BITS-1:0] cur_for(int s);
        logic [ROW_BITS-1:0] v = '0;
        if (s >= 0 && s < TOTAL_STEPS) begin
            int r = s % SUB, b = (s / SUB) % NSUB;
            for (int j = 0; j < SUB; j++)
                v[j*PIX_W +: PIX_W] = PIX_W'(curf[(b/SUB_PER_ROW)*SUB+r][(b%SUB_PER_ROW)*SUB+j]);
        end
        return v;
    endfunction

    function automatic logic [ROW_BITS-1:0] ref_for(int s, int k);
        logic [ROW_BITS-1:0] v = '0;
        if (s >= 0 && s < TOTAL_STEPS) begin
            int r = s % SUB, b = (s / SUB) % NSUB, p = s / STEPS_PER_POS;
            for (int j = 0; j < SUB; j++)
                v[j*PIX_W +: PIX_W] =
                    PIX_W'(reff[(b/SUB_PER_ROW)*SUB+r+p][(b%SUB_PER_ROW)*SUB+j+k]);
        end
        return v;
    endfunction

    task automatic run(int kind, int ignore_at);
        int done_edge = TOTAL_STEPS + SPAN;
        for (int y = 0; y < MB; y++)
            for (int x = 0; x < MB; x++)
                curf[y][x] = (kind == 2) ? 255 : int'($urandom % 256);
        for (int y = 0; y < WIN; y++)
            for (int x = 0; x < WIN; x++)
                reff[y][x] = (kind == 2) ? 0 : int'($urandom % 256);
        full_contrast = (kind == 2);
        push_expected();
        @(negedge clk);
        start_i    = 1'b1;
        cur_row_i  = '0;
        ref_rows_i = '0;
        for (int n = 0; n <= done_edge + 2; n++) begin
            @(negedge clk);
            monitor(n);
            if (n == done_edge - 1 || n == done_edge + 1)
                check(done_o == 1'b0, "R8", "done outside its cycle", done_o, 0);
            if (n == done_edge) begin
                check(done_o == 1'b1, "R8", "done pulse", done_o, 1);
                if (ignore_at > 0)
                    check(done_o == 1'b1, "R2", "done time after ignored start", done_o, 1);
            end
            start_i   = (n + 1 == ignore_at);
            cur_row_i = cur_for(n);
            for (int k = 0; k < SPAN; k++)
                ref_rows_i[k*ROW_BITS +: ROW_BITS] = ref_for(n - k, k);
        end
        check(q.size() == 0, ignore_at > 0 ? "R2" : "R7", "groups left unmatched", q.size(), 0);
        q.delete();
    endtask

    initial begin
        rst        = 1'b1;
        start_i    = 1'b0;
        cur_row_i  = '0;
        ref_rows_i = '0;
        repeat (4) @(negedge clk);
        check(grp_valid_o == 1'b0, "R1", "valid in reset", grp_valid_o, 0);
        check(done_o == 1'b0, "R1", "done in reset", done_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(grp_sad_o == '0, "R1", "sad after reset", grp_sad_o != '0, 0);
        check(grp_mv_o == '0, "R1", "mv after reset", grp_mv_o, 0);
        run(0, 0);
        run(1, 500);
        run(2, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule